// File: doc/BRIEF.md
# Cartridge Bank-Switch Register Decoder

This block sits on an 8-bit CPU write bus with a 16-bit address and turns writes into bank selections for a cartridge memory map. Three registers select 8 KB program-ROM pages for the CPU windows at 8000h, A000h and C000h. The window at E000h always holds the last program page. Eight registers select 1 KB character-ROM pages. Each of these is built from two separate nibble writes that arrive on aliased address offsets. A 2-bit code selects nametable mirroring.

A swap bit in the control register chooses which window the switchable program page drives. Changing the bit exchanges the contents of the 8000h and C000h window registers. This moves the fixed second-to-last page from one window to the other. While the bit is set, writes to the 8000h group land in the C000h register.

The block also forms physical ROM addresses by concatenation. A CPU address in 8000h-FFFFh is prefixed with the page of its window. A 13-bit character address is prefixed with the page of its 1 KB slot. The ROM, the read path and interrupt logic live elsewhere.

Top module: `bank_map_top`

## Requirements
- R1: After reset, the 8000h and A000h window pages are 0, the C000h window page is PRG_BANKS-2, all character pages are 0, the mirroring code is 0 and the swap bit is 0.
- R2: With the swap bit at 0, a write anywhere in 8000h-8FFFh loads the data byte into the 8000h window page. A write anywhere in A000h-AFFFh loads the A000h window page.
- R3: With the swap bit at 1, a write in 8000h-8FFFh loads the C000h window page and leaves the 8000h window page unchanged.
- R4: A write in the 9000h group whose address bits 3:0 are 1h or 4h stores data bit 1 as the swap bit. If that bit differs from the stored swap bit, the 8000h and C000h window pages exchange values in the same cycle; otherwise they keep their values. Address bits 11:4 are ignored.
- R5: A write in the 9000h group with address bits 3:0 equal to 0h sets the mirroring code to data bits 1:0: 0 vertical, 1 horizontal, 2 single-screen low page, 3 single-screen high page.
- R6: A character page register is written as two nibbles, using data bits 3:0 only. The even register of a pair takes its low nibble at offset 0h and its high nibble at offset 2h or 8h. The odd register takes its low nibble at 1h or 4h and its high nibble at 3h or Ch. The offset is address bits 3:0, and address bits 11:4 are ignored. Each write leaves the other nibble unchanged.
- R7: Address group B000h writes character registers 0 and 1, C000h writes 2 and 3, D000h writes 4 and 5, and E000h writes 6 and 7.
- R8: The E000h window page is PRG_BANKS-1 at all times.
- R9: No register changes while the write strobe is low. No register changes on a write to groups 0h-7h or Fh, or on a write in groups 9h or Bh-Eh at an offset that no rule above decodes.
- R10: prg_addr_o is {page of window cpu_addr_i[14:13], cpu_addr_i[12:0]}, with window 0 at 8000h up to window 3 at E000h. chr_addr_o is {character page ppu_addr_i[12:10], ppu_addr_i[9:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| cpu_addr_i | input | 16 | CPU address to translate |
| ppu_addr_i | input | 13 | Character address to translate |
| prg_bank_o | output | 32 | Program pages; byte n drives CPU window n (0 = 8000h) |
| chr_bank_o | output | 64 | Character pages; byte n drives 1 KB slot n |
| mirror_o | output | 2 | Mirroring code |
| prg_addr_o | output | 21 | Physical program-ROM address |
| chr_addr_o | output | 18 | Physical character-ROM address |

## Verification
Program page writes use several offsets inside each group. This shows that only bits 15:12 decode them. Swap control is written with the bit toggled and then with it held, at both alias offsets, which separates a real exchange from a plain reload. Every character register receives a different nibble pair through alternating aliases, with junk in data bits 7:4 and in address bits 11:4. This separates misrouted pairs, swapped nibbles and leaked high data bits. Writes to offsets that decode to nothing, to unused groups and with the strobe low show whether any stray decode alters state.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 8;
  localparam int NIB_W       = DATA_W / 2;
  localparam int PRG_WIN     = 4;
  localparam int CHR_WIN     = 8;
  localparam int PRG_PAGE_AW = 13;
  localparam int CHR_PAGE_AW = 10;
  localparam int CHR_SEL_W   = $clog2(CHR_WIN);
  localparam int PRG_SEL_W   = $clog2(PRG_WIN);
  localparam int PPU_AW      = CHR_PAGE_AW + CHR_SEL_W;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_SCR_LO = 2'd2,
    MIR_SCR_HI = 2'd3
  } mirror_e;

  typedef struct packed {
    logic               prg_sw;
    logic               prg_a;
    logic               ctrl;
    logic               mirr;
    logic [CHR_WIN-1:0] chr_lo;
    logic [CHR_WIN-1:0] chr_hi;
  } wr_stb_t;
endpackage

// File: rtl/bank_map_decode.sv
module bank_map_decode
  import bank_map_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output wr_stb_t           stb_o
);
  logic [3:0] grp, off;
  logic prg_sw, prg_a, ctrl, mirr;
  logic [CHR_WIN-1:0] chr_lo, chr_hi;

  assign grp = wr_addr_i[ADDR_W-1 -: 4];
  assign off = wr_addr_i[3:0];

  assign prg_sw = wr_en_i && (grp == 4'h8);
  assign prg_a  = wr_en_i && (grp == 4'hA);
  assign ctrl   = wr_en_i && (grp == 4'h9) && (off == 4'h1 || off == 4'h4);
  assign mirr   = wr_en_i && (grp == 4'h9) && (off == 4'h0);

  // pair k/2 lives in group B+k/2; odd member uses the shifted aliases
  for (genvar k = 0; k < CHR_WIN; k++) begin : g_chr
    localparam int GRP_I = 11 + k / 2;
    logic hit;
    assign hit = wr_en_i && (grp == 4'(GRP_I));
    if (k % 2 == 0) begin : g_even
      assign chr_lo[k] = hit && (off == 4'h0);
      assign chr_hi[k] = hit && (off == 4'h2 || off == 4'h8);
    end else begin : g_odd
      assign chr_lo[k] = hit && (off == 4'h1 || off == 4'h4);
      assign chr_hi[k] = hit && (off == 4'h3 || off == 4'hC);
    end
  end

  assign stb_o = {prg_sw, prg_a, ctrl, mirr, chr_lo, chr_hi};
endmodule

// File: rtl/bank_map_prg.sv
module bank_map_prg
  import bank_map_pkg::*;
#(
  parameter int PRG_BANKS = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  wr_stb_t                   stb_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic [PRG_WIN*DATA_W-1:0] prg_bank_o,
  output logic [1:0]                mirror_o
);
  localparam logic [DATA_W-1:0] LAST_PG   = DATA_W'(PRG_BANKS - 1);
  localparam logic [DATA_W-1:0] PENULT_PG = DATA_W'(PRG_BANKS - 2);

  logic [DATA_W-1:0] pg_8_q, pg_a_q, pg_c_q;
  logic              swap_q;
  mirror_e           mir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_8_q <= '0;
      pg_a_q <= '0;
      pg_c_q <= PENULT_PG;
      swap_q <= 1'b0;
      mir_q  <= MIR_VERT;
    end else begin
      if (stb_i.prg_sw) begin
        if (swap_q) pg_c_q <= data_i;
        else        pg_8_q <= data_i;
      end
      if (stb_i.prg_a) pg_a_q <= data_i;
      if (stb_i.ctrl) begin
        swap_q <= data_i[1];
        if (data_i[1] != swap_q) begin
          pg_8_q <= pg_c_q;
          pg_c_q <= pg_8_q;
        end
      end
      if (stb_i.mirr) mir_q <= mirror_e'(data_i[1:0]);
    end
  end

  assign prg_bank_o = {LAST_PG, pg_c_q, pg_a_q, pg_8_q};
  assign mirror_o   = mir_q;

  a_r4_swap_exchange: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i.ctrl && data_i[1] != swap_q) |=> (pg_8_q == $past(pg_c_q) && pg_c_q == $past(pg_8_q)));

  a_r3_swapped_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i.prg_sw && swap_q) |=> (pg_c_q == $past(data_i) && $stable(pg_8_q)));

  a_r5_mirror_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i.mirr |=> (mirror_o == $past(data_i[1:0])));
endmodule

// File: rtl/bank_map_chr.sv
module bank_map_chr
  import bank_map_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  wr_stb_t                   stb_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic [CHR_WIN*DATA_W-1:0] chr_bank_o
);
  for (genvar k = 0; k < CHR_WIN; k++) begin : g_reg
    logic [NIB_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (stb_i.chr_lo[k]) lo_q <= data_i[NIB_W-1:0];
        if (stb_i.chr_hi[k]) hi_q <= data_i[NIB_W-1:0];
      end
    end

    assign chr_bank_o[k*DATA_W +: DATA_W] = {hi_q, lo_q};

    a_r6_low_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i.chr_lo[k] |=> (chr_bank_o[k*DATA_W +: NIB_W] == $past(data_i[NIB_W-1:0])
                           && $stable(chr_bank_o[k*DATA_W+NIB_W +: NIB_W])));
  end
endmodule

// File: rtl/bank_map_xlate.sv
module bank_map_xlate
  import bank_map_pkg::*;
(
  input  logic [PRG_WIN*DATA_W-1:0]      prg_bank_i,
  input  logic [CHR_WIN*DATA_W-1:0]      chr_bank_i,
  input  logic [ADDR_W-1:0]              cpu_addr_i,
  input  logic [PPU_AW-1:0]              ppu_addr_i,
  output logic [DATA_W+PRG_PAGE_AW-1:0]  prg_addr_o,
  output logic [DATA_W+CHR_PAGE_AW-1:0]  chr_addr_o
);
  logic [PRG_SEL_W-1:0] prg_win;
  logic [CHR_SEL_W-1:0] chr_win;

  assign prg_win    = cpu_addr_i[PRG_PAGE_AW +: PRG_SEL_W];
  assign chr_win    = ppu_addr_i[CHR_PAGE_AW +: CHR_SEL_W];
  assign prg_addr_o = {prg_bank_i[prg_win*DATA_W +: DATA_W], cpu_addr_i[PRG_PAGE_AW-1:0]};
  assign chr_addr_o = {chr_bank_i[chr_win*DATA_W +: DATA_W], ppu_addr_i[CHR_PAGE_AW-1:0]};
endmodule

// File: rtl/bank_map_top.sv
module bank_map_top
  import bank_map_pkg::*;
#(
  parameter int PRG_BANKS = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  input  logic [ADDR_W-1:0]                 cpu_addr_i,
  input  logic [PPU_AW-1:0]                 ppu_addr_i,
  output logic [PRG_WIN*DATA_W-1:0]         prg_bank_o,
  output logic [CHR_WIN*DATA_W-1:0]         chr_bank_o,
  output logic [1:0]                        mirror_o,
  output logic [DATA_W+PRG_PAGE_AW-1:0]     prg_addr_o,
  output logic [DATA_W+CHR_PAGE_AW-1:0]     chr_addr_o
);
  wr_stb_t stb;

  bank_map_decode u_decode (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .stb_o    (stb)
  );

  bank_map_prg #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (stb),
    .data_i    (wr_data_i),
    .prg_bank_o(prg_bank_o),
    .mirror_o  (mirror_o)
  );

  bank_map_chr u_chr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (stb),
    .data_i    (wr_data_i),
    .chr_bank_o(chr_bank_o)
  );

  bank_map_xlate u_xlate (
    .prg_bank_i(prg_bank_o),
    .chr_bank_i(chr_bank_o),
    .cpu_addr_i(cpu_addr_i),
    .ppu_addr_i(ppu_addr_i),
    .prg_addr_o(prg_addr_o),
    .chr_addr_o(chr_addr_o)
  );

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_o)));

  a_r8_last_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(prg_bank_o[3*DATA_W +: DATA_W]));
endmodule

// File: tb/bank_map_top_tb.sv
module bank_map_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BANKS = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0, cpu_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [12:0] ppu_addr = '0;
  logic [31:0] prg_bank;
  logic [63:0] chr_bank;
  logic [1:0]  mirror;
  logic [20:0] prg_addr;
  logic [17:0] chr_addr;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_prg [4];
  logic [7:0] exp_chr [8];
  logic [1:0] exp_mir;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_map_top #(.PRG_BANKS(BANKS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cpu_addr_i(cpu_addr), .ppu_addr_i(ppu_addr),
    .prg_bank_o(prg_bank), .chr_bank_o(chr_bank), .mirror_o(mirror),
    .prg_addr_o(prg_addr), .chr_addr_o(chr_addr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 4; i++) chk(req, 32'(prg_bank[i*8 +: 8]), 32'(exp_prg[i]));
    for (int i = 0; i < 8; i++) chk(req, 32'(chr_bank[i*8 +: 8]), 32'(exp_chr[i]));
    chk(req, 32'(mirror), 32'(exp_mir));
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    exp_prg = '{8'd0, 8'd0, 8'(BANKS-2), 8'(BANKS-1)};
    for (int i = 0; i < 8; i++) exp_chr[i] = '0;
    exp_mir = 2'd0;
    check_all("R1 reset");
    chk("R8 last window", 32'(prg_bank[31:24]), 32'(BANKS-1));
  endtask

  task automatic t_prg_basic;
    bus_write(16'h8123, 8'h05); exp_prg[0] = 8'h05;
    check_all("R2 8000 group");
    bus_write(16'hAFFF, 8'h07); exp_prg[1] = 8'h07;
    check_all("R2 A000 group");
    bus_write(16'h8F00, 8'h0B); exp_prg[0] = 8'h0B;
    check_all("R2 8000 alias");
  endtask

  task automatic t_swap;
    bus_write(16'h9001, 8'h02);
    exp_prg[0] = 8'(BANKS-2); exp_prg[2] = 8'h0B;
    check_all("R4 toggle exchange");
    bus_write(16'h8000, 8'h09); exp_prg[2] = 8'h09;
    check_all("R3 swapped write");
    bus_write(16'h9FF4, 8'h06);
    check_all("R4 same bit no exchange");
    bus_write(16'h9004, 8'h00);
    exp_prg[0] = 8'h09; exp_prg[2] = 8'(BANKS-2);
    check_all("R4 toggle back");
    bus_write(16'h8001, 8'h11); exp_prg[0] = 8'h11;
    check_all("R2 unswapped again");
    chk("R8 last window", 32'(prg_bank[31:24]), 32'(BANKS-1));
  endtask

  task automatic t_mirror;
    for (int m = 0; m < 4; m++) begin
      bus_write(16'h9A50, {6'b101101, 2'(m)}); exp_mir = 2'(m);
      check_all("R5 mirror");
    end
    bus_write(16'h9000, 8'h01); exp_mir = 2'd1;
    check_all("R5 mirror");
  endtask

  task automatic t_chr;
    for (int k = 0; k < 8; k++) begin
      logic [3:0] grp, lo_off, hi_off, lo_n, hi_n;
      logic [7:0] mid;
      grp = 4'(11 + k / 2);
      mid = (k % 2 == 1) ? 8'hA5 : 8'h00;
      if (k % 2 == 0) begin
        lo_off = 4'h0;
        hi_off = (k % 4 == 0) ? 4'h2 : 4'h8;
      end else begin
        lo_off = (k % 4 == 1) ? 4'h1 : 4'h4;
        hi_off = (k % 4 == 1) ? 4'h3 : 4'hC;
      end
      lo_n = 4'(k + 3);
      hi_n = 4'(k * 5 + 1);
      bus_write({grp, mid, lo_off}, {4'hE, lo_n});
      bus_write({grp, mid, hi_off}, {4'h9, hi_n});
      exp_chr[k] = {hi_n, lo_n};
      check_all("R6 R7 chr pair");
    end
    bus_write(16'hB008, 8'hFC); exp_chr[0] = {4'hC, exp_chr[0][3:0]};
    check_all("R6 high only");
    bus_write(16'hE004, 8'h32); exp_chr[7] = {exp_chr[7][7:4], 4'h2};
    check_all("R6 low only");
  endtask

  task automatic t_ignore;
    bus_write(16'h9002, 8'hFF);
    bus_write(16'h900F, 8'hFF);
    bus_write(16'hB005, 8'hFF);
    bus_write(16'hC00F, 8'hFF);
    bus_write(16'hD006, 8'hFF);
    bus_write(16'h7000, 8'hFF);
    bus_write(16'hF001, 8'hFF);
    bus_write(16'h0000, 8'hFF);
    check_all("R9 unmatched writes");
    @(negedge clk);
    wr_addr = 16'h8000; wr_data = 8'h3C; wr_en = 1'b0;
    @(negedge clk);
    wr_addr = 16'h9001; wr_data = 8'h02;
    @(negedge clk);
    wr_addr = 16'hB000;
    @(negedge clk);
    check_all("R9 strobe low");
  endtask

  task automatic t_xlate;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      cpu_addr = {1'b1, 2'(w), 13'h1ABC};
      #1;
      chk("R10 prg xlate", 32'(prg_addr), 32'({exp_prg[w], 13'h1ABC}));
    end
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      ppu_addr = {3'(s), 10'h2E7};
      #1;
      chk("R10 chr xlate", 32'(chr_addr), 32'({exp_chr[s], 10'h2E7}));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prg_basic();
    t_swap();
    t_mirror();
    t_chr();
    t_ignore();
    t_xlate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule